// File: doc/BRIEF.md
# Bus-Master DMA Channel Control Registers

This block holds the host-visible control state of one bus-master DMA channel. A host reads and writes it over a small byte-addressed register window, with accesses of one, two or four bytes. The window holds a command byte, a status byte and a descriptor-table base pointer. The block turns host commands into start and halt signals for a separate DMA engine. It reloads the engine's table pointer when a run begins, and merges the device interrupt into the status byte.

A run starts only when the stored start bit goes from 0 to 1. Writing the same start value again does nothing. Clearing the start bit never cuts a transfer short. If the engine reports outstanding work, the channel stays active in a draining state until the engine goes idle, and only then drops its active flag. Register reads have no side effects and return data in the same cycle.

Top module: `dma_chan_regs`

## Requirements
- R1: The command byte sits at window offset 0. Only bit 0 (start) and bit 3 (direction) are stored. Every other command bit reads back as 0.
- R2: A command write whose bit 0 equals the stored start bit starts and stops nothing. It gives no `eng_kick` pulse, leaves `cur_ptr` unchanged and leaves the active flag unchanged.
- R3: A command write that changes the start bit from 0 to 1 does four things. It loads `cur_ptr` from the base pointer and sets the active flag. If the channel was not already active, `eng_kick` is high for exactly the one cycle after the write. A restart while draining keeps the channel active with no kick.
- R4: A command write that changes the start bit from 1 to 0 does not abort work in flight. If `eng_busy` is high, `eng_halt` goes high and the active flag stays set until the first clock edge at which `eng_busy` is low. If `eng_busy` is low, the active flag clears at the write itself.
- R5: A rising edge on `dev_irq` sets status bit 2 (interrupt). `irq_out` follows `dev_irq` at both levels. A falling edge leaves the status unchanged.
- R6: The status byte sits at offset 2: bit 0 active (read-only), bit 1 error (set by an `eng_err` pulse), bit 2 interrupt. Writing 1 to bit 1 or bit 2 clears that bit. A set and a clear in the same cycle leave the bit set. Status bits 7:3 read 0.
- R7: Offsets 1 and 3 read 0. The base pointer occupies offsets 4 to 7, least significant byte first. A read at offset `a` returns the window bytes from `a` upward in ascending data lanes: 1, 2 or 4 bytes for `reg_size` 0, 1 or 2, and 4 bytes for `reg_size` 3. Bytes past the window read 0.
- R8: A write changes only the bytes it covers. Bits 1:0 of the base pointer are always 0, whichever lanes were written.
- R9: `eng_dir` takes command bit 3 only on a 0-to-1 start transition and holds its value through any other command write.
- R10: Reset returns the command, status and base pointer to 0. It also clears `cur_ptr`, `eng_dir`, `eng_halt` and `eng_kick`, and leaves the channel idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 3 | Byte offset of the access within the window |
| reg_size | input | 2 | Access width: 0 one byte, 1 two bytes, 2 or 3 four bytes |
| reg_wr | input | 1 | Write strobe, one write per cycle it is high |
| reg_wdata | input | 32 | Write data, lowest addressed byte in bits 7:0 |
| reg_rdata | output | 32 | Same-cycle read data, lowest addressed byte in bits 7:0 |
| eng_busy | input | 1 | Engine has a transfer outstanding |
| eng_err | input | 1 | Engine error pulse |
| eng_kick | output | 1 | One-cycle request to begin a run |
| eng_halt | output | 1 | Stop requested, waiting for the engine to go idle |
| eng_dir | output | 1 | Direction captured at the last start |
| cur_ptr | output | 32 | Descriptor-table pointer loaded at start |
| dev_irq | input | 1 | Device interrupt level |
| irq_out | output | 1 | Forwarded interrupt level |

## Verification
If the run state is wrong, it appears within one cycle of the command write. The active bit reads back wrongly at offset 2, or `eng_kick` fires on a repeated start or stays quiet on a real one. A drain that ends early drops the active bit while `eng_busy` is still high, which the bench watches cycle by cycle. A bad lane decode or a lost alignment mask shows at once in the same-cycle read of the base bytes, which the bench sweeps at every offset and width. A missed interrupt edge shows in the status byte one cycle after `dev_irq` rises.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;

    // Byte offsets inside the register window
    localparam int OFS_CMD  = 0;
    localparam int OFS_STAT = 2;
    localparam int OFS_BASE = 4;

    // Command byte bit positions
    localparam int CMD_START_BIT = 0;
    localparam int CMD_DIR_BIT   = 3;

    // Status byte bit positions
    localparam int ST_ACT_BIT = 0;
    localparam int ST_ERR_BIT = 1;
    localparam int ST_INT_BIT = 2;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_WORDX = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        RUN_IDLE  = 2'd0,
        RUN_BUSY  = 2'd1,
        RUN_DRAIN = 2'd2
    } run_state_e;

    typedef struct packed {
        logic dir;
        logic start;
    } cmd_t;

    typedef struct packed {
        logic intr;
        logic err;
        logic active;
    } stat_t;

    function automatic int size_bytes(input logic [1:0] sz);
        case (acc_size_e'(sz))
            SZ_BYTE: return 1;
            SZ_HALF: return 2;
            default: return 4;
        endcase
    endfunction

    function automatic logic [7:0] cmd_byte(input cmd_t c);
        logic [7:0] b;
        b = 8'h00;
        b[CMD_START_BIT] = c.start;
        b[CMD_DIR_BIT]   = c.dir;
        return b;
    endfunction

    function automatic logic [7:0] stat_byte(input stat_t s);
        logic [7:0] b;
        b = 8'h00;
        b[ST_ACT_BIT] = s.active;
        b[ST_ERR_BIT] = s.err;
        b[ST_INT_BIT] = s.intr;
        return b;
    endfunction

endpackage

// File: rtl/dma_lane_io.sv
module dma_lane_io
    import dma_regs_pkg::*;
#(
    parameter int BUS_BYTES = 4,
    parameter int WIN_BYTES = 8,
    parameter int WIN_AW    = 3
) (
    input  logic [WIN_AW-1:0]      acc_addr,
    input  logic [1:0]             acc_size,
    input  logic                   acc_wr,
    input  logic [8*BUS_BYTES-1:0] acc_wdata,
    input  logic [8*WIN_BYTES-1:0] win_bytes,
    output logic [WIN_BYTES-1:0]   lane_we,
    output logic [8*WIN_BYTES-1:0] lane_wd,
    output logic [8*BUS_BYTES-1:0] acc_rdata
);

    int nbytes;

    always_comb begin
        nbytes = size_bytes(acc_size);
        if (nbytes > BUS_BYTES) begin
            nbytes = BUS_BYTES;
        end
        lane_we   = '0;
        lane_wd   = '0;
        acc_rdata = '0;
        for (int j = 0; j < WIN_BYTES; j++) begin
            for (int k = 0; k < BUS_BYTES; k++) begin
                if ((k < nbytes) && (int'(acc_addr) + k == j)) begin
                    lane_we[j]          = acc_wr;
                    lane_wd[j*8 +: 8]   = acc_wdata[k*8 +: 8];
                    acc_rdata[k*8 +: 8] = win_bytes[j*8 +: 8];
                end
            end
        end
    end

endmodule

// File: rtl/dma_run_ctl.sv
module dma_run_ctl
    import dma_regs_pkg::*;
#(
    parameter int PTR_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_we,
    input  logic             wr_start,
    input  logic             wr_dir,
    input  logic [PTR_W-1:0] base_ptr,
    input  logic             eng_busy,
    output cmd_t             cmd_q,
    output logic             active,
    output logic             kick,
    output logic             halt,
    output logic             dir_q,
    output logic [PTR_W-1:0] cur_ptr
);

    run_state_e state;

    assign active = (state != RUN_IDLE);
    assign halt   = (state == RUN_DRAIN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= RUN_IDLE;
            cmd_q   <= '0;
            kick    <= 1'b0;
            dir_q   <= 1'b0;
            cur_ptr <= '0;
        end else begin
            kick <= 1'b0;
            // outstanding work finished: the pending stop completes
            if (state == RUN_DRAIN && !eng_busy) begin
                state <= RUN_IDLE;
            end
            if (cmd_we) begin
                cmd_q.start <= wr_start;
                cmd_q.dir   <= wr_dir;
                if (wr_start != cmd_q.start) begin
                    if (wr_start) begin
                        cur_ptr <= base_ptr;
                        dir_q   <= wr_dir;
                        kick    <= (state == RUN_IDLE);
                        state   <= RUN_BUSY;
                    end else if (eng_busy) begin
                        state <= RUN_DRAIN;
                    end else begin
                        state <= RUN_IDLE;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/dma_stat_irq.sv
module dma_stat_irq (
    input  logic clk,
    input  logic rst,
    input  logic dev_irq,
    input  logic eng_err,
    input  logic clr_err,
    input  logic clr_int,
    output logic err_q,
    output logic int_q,
    output logic irq_out
);

    logic dev_irq_q;
    logic irq_rise;

    assign irq_rise = dev_irq && !dev_irq_q;
    assign irq_out  = dev_irq;

    always_ff @(posedge clk) begin
        if (rst) begin
            dev_irq_q <= 1'b0;
            err_q     <= 1'b0;
            int_q     <= 1'b0;
        end else begin
            dev_irq_q <= dev_irq;
            // a set in the same cycle as a clear wins
            if (irq_rise) begin
                int_q <= 1'b1;
            end else if (clr_int) begin
                int_q <= 1'b0;
            end
            if (eng_err) begin
                err_q <= 1'b1;
            end else if (clr_err) begin
                err_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dma_regs_pkg::*;
#(
    parameter int BUS_BYTES = 4,
    parameter int PTR_BYTES = 4,
    localparam int PTR_W     = 8 * PTR_BYTES,
    localparam int WIN_AW    = $clog2(OFS_BASE + PTR_BYTES),
    localparam int WIN_BYTES = 1 << WIN_AW
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [WIN_AW-1:0]      reg_addr,
    input  logic [1:0]             reg_size,
    input  logic                   reg_wr,
    input  logic [8*BUS_BYTES-1:0] reg_wdata,
    output logic [8*BUS_BYTES-1:0] reg_rdata,
    input  logic                   eng_busy,
    input  logic                   eng_err,
    output logic                   eng_kick,
    output logic                   eng_halt,
    output logic                   eng_dir,
    output logic [PTR_W-1:0]       cur_ptr,
    input  logic                   dev_irq,
    output logic                   irq_out
);

    logic [WIN_BYTES-1:0]   lane_we;
    logic [8*WIN_BYTES-1:0] lane_wd;
    logic [8*WIN_BYTES-1:0] win_bytes;
    logic [PTR_W-1:0]       base_q;
    cmd_t                   cmd_q;
    stat_t                  stat_q;
    logic                   active;
    logic                   err_q;
    logic                   int_q;
    logic                   cmd_we;
    logic                   cmd_wr_start;
    logic                   cmd_wr_dir;
    logic                   unused_lanes;

    dma_lane_io #(
        .BUS_BYTES(BUS_BYTES),
        .WIN_BYTES(WIN_BYTES),
        .WIN_AW   (WIN_AW)
    ) u_lanes (
        .acc_addr (reg_addr),
        .acc_size (reg_size),
        .acc_wr   (reg_wr),
        .acc_wdata(reg_wdata),
        .win_bytes(win_bytes),
        .lane_we  (lane_we),
        .lane_wd  (lane_wd),
        .acc_rdata(reg_rdata)
    );

    assign cmd_we       = lane_we[OFS_CMD];
    assign cmd_wr_start = lane_wd[OFS_CMD*8 + CMD_START_BIT];
    assign cmd_wr_dir   = lane_wd[OFS_CMD*8 + CMD_DIR_BIT];

    dma_run_ctl #(
        .PTR_W(PTR_W)
    ) u_run (
        .clk     (clk),
        .rst     (rst),
        .cmd_we  (cmd_we),
        .wr_start(cmd_wr_start),
        .wr_dir  (cmd_wr_dir),
        .base_ptr(base_q),
        .eng_busy(eng_busy),
        .cmd_q   (cmd_q),
        .active  (active),
        .kick    (eng_kick),
        .halt    (eng_halt),
        .dir_q   (eng_dir),
        .cur_ptr (cur_ptr)
    );

    dma_stat_irq u_stat (
        .clk    (clk),
        .rst    (rst),
        .dev_irq(dev_irq),
        .eng_err(eng_err),
        .clr_err(lane_we[OFS_STAT] && lane_wd[OFS_STAT*8 + ST_ERR_BIT]),
        .clr_int(lane_we[OFS_STAT] && lane_wd[OFS_STAT*8 + ST_INT_BIT]),
        .err_q  (err_q),
        .int_q  (int_q),
        .irq_out(irq_out)
    );

    // Base pointer: byte-lane writes, low two bits held at zero
    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
        end else begin
            for (int b = 0; b < PTR_BYTES; b++) begin
                if (lane_we[OFS_BASE + b]) begin
                    base_q[b*8 +: 8] <= lane_wd[(OFS_BASE + b)*8 +: 8];
                end
            end
            base_q[1:0] <= 2'b00;
        end
    end

    assign stat_q = '{intr: int_q, err: err_q, active: active};

    always_comb begin
        win_bytes                      = '0;
        win_bytes[OFS_CMD*8 +: 8]      = cmd_byte(cmd_q);
        win_bytes[OFS_STAT*8 +: 8]     = stat_byte(stat_q);
        win_bytes[OFS_BASE*8 +: PTR_W] = base_q;
    end

    assign unused_lanes = ^{lane_we, lane_wd};

endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk #(
    parameter int PTR_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             cmd_we,
    input logic             cmd_wr_start,
    input logic             cmd_start,
    input logic             active,
    input logic             eng_kick,
    input logic             eng_halt,
    input logic             eng_busy,
    input logic             eng_dir,
    input logic             dev_irq,
    input logic             int_q,
    input logic [PTR_W-1:0] cur_ptr,
    input logic [PTR_W-1:0] base_q
);

    AST_SAME_START_NOP: assert property (@(posedge clk) disable iff (rst)
        (cmd_we && cmd_wr_start == cmd_start) |=> (!eng_kick && $stable(cur_ptr))); // R2

    AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
        (cmd_we && cmd_wr_start && !cmd_start && !active) |=> (eng_kick && active && cur_ptr == $past(base_q))); // R3

    AST_DRAIN_KEEPS_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        (eng_halt && eng_busy) |=> active); // R4

    AST_IDLE_STOP: assert property (@(posedge clk) disable iff (rst)
        (cmd_we && !cmd_wr_start && cmd_start && !eng_busy) |=> (!active && !eng_halt)); // R4

    AST_IRQ_EDGE_LATCH: assert property (@(posedge clk) disable iff (rst)
        $rose(dev_irq) |=> int_q); // R5

    AST_PTR_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        cur_ptr[1:0] == 2'b00); // R8

    AST_DIR_HELD: assert property (@(posedge clk) disable iff (rst)
        !(cmd_we && cmd_wr_start && !cmd_start) |=> $stable(eng_dir)); // R9

    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (!active && !eng_kick && !eng_halt && !cmd_start && !int_q && cur_ptr == '0)); // R10

endmodule

bind dma_chan_regs dma_chan_regs_chk #(
    .PTR_W(PTR_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cmd_we      (cmd_we),
    .cmd_wr_start(cmd_wr_start),
    .cmd_start   (cmd_q.start),
    .active      (active),
    .eng_kick    (eng_kick),
    .eng_halt    (eng_halt),
    .eng_busy    (eng_busy),
    .eng_dir     (eng_dir),
    .dev_irq     (dev_irq),
    .int_q       (int_q),
    .cur_ptr     (cur_ptr),
    .base_q      (base_q)
);

// File: tb/dma_chan_regs_test.sv
`timescale 1ns/1ps
module dma_chan_regs_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  reg_addr = '0;
    logic [1:0]  reg_size = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        eng_busy = 1'b0;
    logic        eng_err = 1'b0;
    logic        eng_kick;
    logic        eng_halt;
    logic        eng_dir;
    logic [31:0] cur_ptr;
    logic        dev_irq = 1'b0;
    logic        irq_out;

    int checks = 0;
    int errors = 0;

    logic [7:0]  m_cmd = 8'h00;
    logic [7:0]  m_stat = 8'h00;
    logic [31:0] m_base = 32'h0;

    always #2.5 clk = ~clk;

    dma_chan_regs uut (
        .clk(clk), .rst(rst),
        .reg_addr(reg_addr), .reg_size(reg_size), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .eng_busy(eng_busy), .eng_err(eng_err),
        .eng_kick(eng_kick), .eng_halt(eng_halt), .eng_dir(eng_dir),
        .cur_ptr(cur_ptr), .dev_irq(dev_irq), .irq_out(irq_out)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input int a, input int sz, input logic [31:0] d);
        reg_addr  = a[2:0];
        reg_size  = sz[1:0];
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd(input int a, input int sz, output logic [31:0] d);
        reg_addr = a[2:0];
        reg_size = sz[1:0];
        #1;
        d = reg_rdata;
    endtask

    function automatic logic [31:0] exp_read(input int a, input int sz);
        logic [7:0]  w [8];
        logic [31:0] r;
        int n;
        w[0] = m_cmd; w[1] = 8'h00; w[2] = m_stat; w[3] = 8'h00;
        for (int i = 0; i < 4; i++) w[4+i] = m_base[i*8 +: 8];
        n = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
        r = '0;
        for (int k = 0; k < n; k++) begin
            if (a + k < 8) r[k*8 +: 8] = w[a+k];
        end
        return r;
    endfunction

    task automatic sweep_reads(input string req);
        logic [31:0] d;
        for (int a = 0; a < 8; a++) begin
            for (int sz = 0; sz < 4; sz++) begin
                rd(a, sz, d);
                chk(req, d, exp_read(a, sz));
            end
        end
    endtask

    task automatic read_stat(input string req, input logic [7:0] exp);
        logic [31:0] d;
        rd(2, 0, d);
        chk(req, d, {24'h0, exp});
    endtask

    initial begin
        #(5.0 * 20000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [31:0] ptr0;
        @(negedge clk);
        step(); step();
        rst = 1'b0;

        // R10: everything reads zero after reset
        sweep_reads("R10 reset window");
        chk("R10 reset ptr", cur_ptr, 32'h0);
        chk("R10 reset outputs", {29'h0, eng_kick, eng_halt, eng_dir}, 32'h0);

        // R7 R8: lane writes into the base pointer, then sweep all reads
        for (int a = 4; a < 8; a++) begin
            for (int sz = 0; sz < 3; sz++) begin
                logic [31:0] pat;
                int n;
                pat = 32'hA5C3_96F1 ^ (32'h0101_0101 * (a * 4 + sz + 7));
                n = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
                wr(a, sz, pat);
                for (int k = 0; k < n; k++) begin
                    if (a + k < 8) m_base[(a + k - 4)*8 +: 8] = pat[k*8 +: 8];
                end
                m_base[1:0] = 2'b00;
                rd(4, 2, d);
                chk("R8 base lane write", d, m_base);
            end
        end
        sweep_reads("R7 window read");

        // R1: command mask
        wr(0, 0, 32'h0000_00F6);
        rd(0, 0, d);
        chk("R1 cmd mask", d, 32'h00);
        chk("R1 no kick", {31'h0, eng_kick}, 32'h0);
        wr(0, 0, 32'h0000_00FE);
        m_cmd = 8'h08;
        rd(0, 0, d);
        chk("R1 dir stored", d, 32'h08);

        // R3 R9: start from idle with direction 1
        ptr0 = m_base;
        wr(0, 0, 32'h0000_0009);
        m_cmd = 8'h09; m_stat = 8'h01;
        chk("R3 kick pulse", {31'h0, eng_kick}, 32'h1);
        chk("R3 ptr reload", cur_ptr, ptr0);
        chk("R9 dir captured", {31'h0, eng_dir}, 32'h1);
        read_stat("R3 active set", 8'h01);
        step();
        chk("R3 kick one cycle", {31'h0, eng_kick}, 32'h0);

        // R6: active bit is read-only
        wr(2, 0, 32'h0000_0001);
        read_stat("R6 active read-only", 8'h01);

        // R2 R9: repeated start is ignored, new base not taken
        wr(4, 2, 32'h1234_567B);
        m_base = 32'h1234_5678;
        wr(0, 0, 32'h0000_0001);
        m_cmd = 8'h01;
        chk("R2 no kick", {31'h0, eng_kick}, 32'h0);
        chk("R2 ptr kept", cur_ptr, ptr0);
        chk("R9 dir held", {31'h0, eng_dir}, 32'h1);
        sweep_reads("R2 window after repeat");

        // R4: stop with work outstanding
        eng_busy = 1'b1;
        wr(0, 0, 32'h0000_0000);
        m_cmd = 8'h00;
        read_stat("R4 active while busy", 8'h01);
        chk("R4 halt raised", {31'h0, eng_halt}, 32'h1);
        for (int i = 0; i < 3; i++) begin
            step();
            read_stat("R4 drain holds", 8'h01);
        end
        eng_busy = 1'b0;
        step();
        m_stat = 8'h00;
        read_stat("R4 drain done", 8'h00);
        chk("R4 halt cleared", {31'h0, eng_halt}, 32'h0);

        // R3 R9: start again with direction 0, then idle stop
        wr(0, 0, 32'h0000_0001);
        chk("R3 second kick", {31'h0, eng_kick}, 32'h1);
        chk("R3 new ptr", cur_ptr, 32'h1234_5678);
        chk("R9 dir zero", {31'h0, eng_dir}, 32'h0);
        wr(0, 0, 32'h0000_0000);
        read_stat("R4 idle stop", 8'h00);

        // R3: restart during drain keeps active, no kick
        wr(0, 0, 32'h0000_0001);
        eng_busy = 1'b1;
        wr(0, 0, 32'h0000_0000);
        chk("R4 halt on stop", {31'h0, eng_halt}, 32'h1);
        wr(0, 0, 32'h0000_0001);
        chk("R3 restart no kick", {31'h0, eng_kick}, 32'h0);
        chk("R3 restart halt off", {31'h0, eng_halt}, 32'h0);
        read_stat("R3 restart active", 8'h01);
        step();
        read_stat("R3 restart stays", 8'h01);
        eng_busy = 1'b0;
        wr(0, 0, 32'h0000_0000);
        read_stat("R4 final stop", 8'h00);

        // R5: interrupt latching
        dev_irq = 1'b1;
        step();
        read_stat("R5 rise sets", 8'h04);
        chk("R5 irq high", {31'h0, irq_out}, 32'h1);
        wr(2, 0, 32'h0000_0004);
        read_stat("R6 int clear while high", 8'h00);
        dev_irq = 1'b0;
        step();
        chk("R5 irq low", {31'h0, irq_out}, 32'h0);
        read_stat("R5 fall no set", 8'h00);
        dev_irq = 1'b1;
        step();
        dev_irq = 1'b0;
        step();
        read_stat("R5 fall keeps", 8'h04);
        wr(2, 0, 32'h0000_0004);
        read_stat("R6 int cleared", 8'h00);

        // R6: error bit, clear and set-wins
        eng_err = 1'b1;
        step();
        eng_err = 1'b0;
        read_stat("R6 err set", 8'h02);
        wr(2, 0, 32'h0000_0002);
        read_stat("R6 err cleared", 8'h00);
        eng_err = 1'b1;
        wr(2, 0, 32'h0000_0002);
        eng_err = 1'b0;
        read_stat("R6 set wins", 8'h02);
        wr(0, 2, 32'hFFFF_0000);
        read_stat("R6 wide clear", 8'h00);

        // R10: reset in the middle of a run
        wr(0, 0, 32'h0000_0009);
        dev_irq = 1'b1;
        step();
        dev_irq = 1'b0;
        rst = 1'b1;
        step(); step();
        rst = 1'b0;
        m_cmd = 8'h00; m_stat = 8'h00; m_base = 32'h0;
        sweep_reads("R10 reset mid-run");
        chk("R10 ptr cleared", cur_ptr, 32'h0);
        chk("R10 outputs cleared", {29'h0, eng_kick, eng_halt, eng_dir}, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule